// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the control front end of a four-channel 8-bit converter. A three-wire serial port (serial clock, serial data and an enable) carries 12-bit words into the chip. Each word writes either one of four channel code registers or a control register. The control register holds a one-way mode bit and a gain-select bit for each channel's output amplifier. The serial pins are sampled in the `clk_i` domain. A data bit is taken on each falling edge of the serial clock.

Every register has two ranks. Words land in the first rank. While the mode bit is clear, the second rank, which drives the outputs, copies the first rank only while the enable is low. Software can therefore load several channels and then move them all to the outputs at once by pulling the enable low. Once the mode bit is set, it cannot be cleared. From then on, the second rank follows every completed word without any enable activity.

Top module: `sdac_serial_if`

## Requirements
- R1: After reset, all four channel codes are 0, all gain bits are 0 (x1), and the mode bit is 0 (double-buffered).
- R2: A word is a 1 start bit followed by 11 bits, most significant first. If the select bit is 0, the next 2 bits choose the channel (00 = A, 01 = B, 10 = C, 11 = D). The final 8 bits are that channel's code, sent D7 first.
- R3: Zero bits seen while the receiver is idle are discarded. The receiver starts counting a word only at the first 1.
- R4: While the mode bit is 0 and the enable is high, the code and gain outputs hold their values. While the enable is low, every channel's output takes its first-rank value, so all channels change together.
- R5: A low enable clears the receiver. Any bits of an unfinished word are discarded.
- R6: A select bit of 1 marks a control word. Its next bit is the mode bit, the following 4 bits are the gain bits for channels A, B, C and D in that order (1 = x2), and the last 5 bits are ignored. Gain bits are double-buffered in the same way as the codes.
- R7: Once the mode bit is 1, a control word with a 0 mode bit leaves it at 1.
- R8: While the mode bit is 1, the target register and its output update without any enable pulse. The output changes two `clk_i` cycles after the cycle that samples the twelfth falling edge.
- R9: Twelve or more consecutive 0 bits always return the receiver to idle. A word left unfinished is completed with those zeros.
- R10: A word ends exactly at its twelfth bit. The next bit is treated as idle input or as a new start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; a bit is taken on its falling edge |
| sdat_i | input | 1 | Serial data |
| sen_i | input | 1 | Enable: low clears the receiver and, in double-buffered mode, loads the outputs |
| code_o | output | 32 | Latched codes, channel A in bits 7:0 up to channel D in bits 31:24 |
| gain_o | output | 4 | Latched gain selects, bit 0 = channel A, 1 = x2 |

## Verification
The design assumes the serial pins are already synchronous to `clk_i`. Each serial clock level must be held for at least one `clk_i` cycle, and data must be stable when a falling edge is sampled. The enable may change only while the serial clock is low. The bench keeps to these rules by holding each serial clock phase for two cycles, changing data only while the serial clock is high, and moving the enable only between bits. Random words vary the number of leading zeros and the enable pulses. Directed cases cover an aborted word, the zero-run resync, back-to-back words and the attempt to clear the mode bit.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam logic SEL_DAC  = 1'b0;
  localparam logic SEL_CTRL = 1'b1;

  typedef enum logic {RX_IDLE = 1'b0, RX_SHIFT = 1'b1} rx_state_e;
endpackage

// File: rtl/sdac_ser_rx.sv
module sdac_ser_rx #(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sen_i,
  output logic              vld_o,
  output logic [WORD_W-2:0] word_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  cnt_o
);
  import sdac_pkg::*;

  rx_state_e         state_q;
  logic              sclk_q;
  logic              vld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] sh_q;
  logic              fall;

  assign fall = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      sclk_q  <= 1'b0;
      vld_q   <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      sclk_q <= sclk_i;
      vld_q  <= 1'b0;
      if (!sen_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (fall) begin
        if (state_q == RX_IDLE) begin
          // leading zeros dropped; a 1 is the start bit (bit 1 of 12)
          if (sdat_i) begin
            state_q <= RX_SHIFT;
            cnt_q   <= CNT_W'(1);
          end
        end else begin
          sh_q <= {sh_q[WORD_W-3:0], sdat_i};
          if (cnt_q == CNT_W'(WORD_W-1)) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            vld_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign vld_o  = vld_q;
  assign word_o = sh_q;
  assign busy_o = (state_q == RX_SHIFT);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH),
  localparam int unsigned PAY_W  = ADDR_W + CODE_W
) (
  input  logic              vld_i,
  input  logic [PAY_W:0]    word_i,
  output logic [NUM_CH-1:0] dac_we_o,
  output logic [CODE_W-1:0] code_o,
  output logic              ctrl_we_o,
  output logic              mode_set_o,
  output logic [NUM_CH-1:0] gain_o
);
  import sdac_pkg::*;

  logic              sel;
  logic [ADDR_W-1:0] addr;

  assign sel        = word_i[PAY_W];
  assign addr       = word_i[PAY_W-1 -: ADDR_W];
  assign code_o     = word_i[CODE_W-1:0];
  assign ctrl_we_o  = vld_i && (sel == SEL_CTRL);
  assign mode_set_o = word_i[PAY_W-1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    assign dac_we_o[ch] = vld_i && (sel == SEL_DAC) && (addr == ADDR_W'(ch));
    // gain bits follow the mode bit, channel A first
    assign gain_o[ch]   = word_i[PAY_W-2-ch];
  end
endmodule

// File: rtl/sdac_bank.sv
module sdac_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sen_i,
  input  logic [NUM_CH-1:0]        dac_we_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     ctrl_we_i,
  input  logic                     mode_set_i,
  input  logic [NUM_CH-1:0]        gain_i,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        gain_o,
  output logic                     mode_o
);
  logic mode_q;
  logic load_out;

  // second rank copies while enable low, or always once single-buffered
  assign load_out = mode_q | ~sen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      mode_q <= 1'b0;
    else if (ctrl_we_i && mode_set_i) mode_q <= 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0] code_rank1_q, code_rank2_q;
    logic              gain_rank1_q, gain_rank2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_rank1_q <= '0;
        gain_rank1_q <= 1'b0;
      end else begin
        if (dac_we_i[ch]) code_rank1_q <= code_i;
        if (ctrl_we_i)    gain_rank1_q <= gain_i[ch];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_rank2_q <= '0;
        gain_rank2_q <= 1'b0;
      end else if (load_out) begin
        code_rank2_q <= code_rank1_q;
        gain_rank2_q <= gain_rank1_q;
      end
    end

    assign code_o[ch*CODE_W +: CODE_W] = code_rank2_q;
    assign gain_o[ch]                  = gain_rank2_q;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sdac_serial_if.sv
module sdac_serial_if #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned ADDR_W = $clog2(NUM_CH),
  localparam int unsigned WORD_W = 2 + ADDR_W + CODE_W,
  localparam int unsigned CNT_W  = $clog2(WORD_W)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     sdat_i,
  input  logic                     sen_i,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        gain_o
);
  logic              word_vld;
  logic [WORD_W-2:0] rx_word;
  logic              rx_busy;
  logic [CNT_W-1:0]  rx_cnt;
  logic [NUM_CH-1:0] dac_we;
  logic [CODE_W-1:0] wr_code;
  logic              ctrl_we;
  logic              mode_set;
  logic [NUM_CH-1:0] wr_gain;
  logic              mode_q;

  sdac_ser_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdat_i (sdat_i),
    .sen_i  (sen_i),
    .vld_o  (word_vld),
    .word_o (rx_word),
    .busy_o (rx_busy),
    .cnt_o  (rx_cnt)
  );

  sdac_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
    .vld_i      (word_vld),
    .word_i     (rx_word),
    .dac_we_o   (dac_we),
    .code_o     (wr_code),
    .ctrl_we_o  (ctrl_we),
    .mode_set_o (mode_set),
    .gain_o     (wr_gain)
  );

  sdac_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sen_i      (sen_i),
    .dac_we_i   (dac_we),
    .code_i     (wr_code),
    .ctrl_we_i  (ctrl_we),
    .mode_set_i (mode_set),
    .gain_i     (wr_gain),
    .code_o     (code_o),
    .gain_o     (gain_o),
    .mode_o     (mode_q)
  );
endmodule

// File: rtl/sdac_serial_if_chk.sv
module sdac_serial_if_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned WORD_W = 12,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sen_i,
  input logic                     mode_q,
  input logic                     word_vld,
  input logic                     rx_busy,
  input logic [CNT_W-1:0]         rx_cnt,
  input logic [NUM_CH*CODE_W-1:0] code_o,
  input logic [NUM_CH-1:0]        gain_o
);
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> mode_q); // R7

  AST_DOUBLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && sen_i) |=> ($stable(code_o) && $stable(gain_o))); // R4

  AST_EN_CLEARS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_i |=> (!rx_busy && rx_cnt == '0)); // R5

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt < CNT_W'(WORD_W)); // R10

  AST_WORD_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld |-> (!rx_busy && rx_cnt == '0)); // R10

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld |=> !word_vld); // R10
endmodule

bind sdac_serial_if sdac_serial_if_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sen_i    (sen_i),
  .mode_q   (mode_q),
  .word_vld (word_vld),
  .rx_busy  (rx_busy),
  .rx_cnt   (rx_cnt),
  .code_o   (code_o),
  .gain_o   (gain_o)
);

// File: tb/sdac_serial_if_tb.sv
module sdac_serial_if_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0;
  logic        sdat_i = 1'b0;
  logic        sen_i = 1'b1;
  logic [31:0] code_o;
  logic [3:0]  gain_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_r1 [4];
  logic [7:0] m_out [4];
  logic [3:0] m_g1, m_gout;
  bit         m_mode;

  always #2.5 clk_i = ~clk_i;

  sdac_serial_if u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdat_i (sdat_i),
    .sen_i  (sen_i),
    .code_o (code_o),
    .gain_o (gain_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(code_o[c*8 +: 8]), 32'(m_out[c]));
    chk(req, 32'(gain_o), 32'(m_gout));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic ser_bit(input logic b);
    sdat_i = b;
    sclk_i = 1'b1;
    wait_clk(2);
    sclk_i = 1'b0;
    wait_clk(2);
  endtask

  // model of one completed word; w = select bit and the 10 bits after it
  function automatic void apply_word(input logic [10:0] w);
    if (w[10]) begin
      if (w[9]) m_mode = 1'b1;
      for (int c = 0; c < 4; c++) m_g1[c] = w[8-c];
    end else begin
      m_r1[w[9:8]] = w[7:0];
    end
    if (m_mode) begin
      for (int c = 0; c < 4; c++) m_out[c] = m_r1[c];
      m_gout = m_g1;
    end
  endfunction

  task automatic send_word(input logic [10:0] w, input int lead);
    for (int i = 0; i < lead; i++) ser_bit(1'b0);
    ser_bit(1'b1);
    for (int i = 10; i >= 0; i--) ser_bit(w[i]);
    apply_word(w);
    wait_clk(3);
  endtask

  task automatic en_pulse();
    sen_i = 1'b0;
    wait_clk(3);
    sen_i = 1'b1;
    if (!m_mode) begin
      for (int c = 0; c < 4; c++) m_out[c] = m_r1[c];
      m_gout = m_g1;
    end
    wait_clk(1);
  endtask

  function automatic logic [10:0] dac_w(input logic [1:0] ch, input logic [7:0] d);
    return {1'b0, ch, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [10:0] w;
    int unsigned seed;
    seed = $urandom(32'h5eed_2024);
    for (int c = 0; c < 4; c++) begin m_r1[c] = '0; m_out[c] = '0; end
    m_g1 = '0; m_gout = '0; m_mode = 1'b0;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    chk_outs("R1 reset");

    // R2 R4: two channels load, outputs hold, then update together
    send_word(dac_w(2'b00, 8'h5A), 0);
    send_word(dac_w(2'b01, 8'hC3), 0);
    chk_outs("R4 hold while enable high");
    en_pulse();
    chk_outs("R2 R4 joint update");

    // R3: leading zeros
    send_word(dac_w(2'b10, 8'h81), 5);
    en_pulse();
    chk_outs("R3 leading zeros");

    // R5: partial word discarded by low enable
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1); ser_bit(1'b1); ser_bit(1'b1);
    sen_i = 1'b0; wait_clk(2); sen_i = 1'b1; wait_clk(1);
    send_word(dac_w(2'b11, 8'h3C), 0);
    en_pulse();
    chk_outs("R5 aborted word");

    // R9: partial word (start, DAC, addr msb 1) completed by zeros -> C = 0
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    for (int i = 0; i < 12; i++) ser_bit(1'b0);
    apply_word(dac_w(2'b10, 8'h00));
    send_word(dac_w(2'b01, 8'h77), 0);
    en_pulse();
    chk_outs("R9 zero run resync");

    // R10: back-to-back words, no gap bits
    for (int i = 10; i >= 0; i--) ; // no-op spacer
    ser_bit(1'b1);
    for (int i = 10; i >= 0; i--) ser_bit(dac_w(2'b00, 8'hE1)[i]);
    apply_word(dac_w(2'b00, 8'hE1));
    send_word(dac_w(2'b11, 8'h1F), 0);
    en_pulse();
    chk_outs("R10 word boundary");

    // R6: control word, gains A and C = x2, reserved bits set
    send_word({1'b1, 1'b0, 4'b1010, 5'b11111}, 2);
    chk_outs("R6 gains held before enable");
    en_pulse();
    chk_outs("R6 gains after enable");

    // R4: random double-buffered traffic
    for (int k = 0; k < 150; k++) begin
      w = 11'($urandom);
      if (w[10]) w[9] = 1'b0;
      send_word(w, int'($urandom % 4));
      if ($urandom % 3 == 0) en_pulse();
      chk_outs("R4 random double-buffered");
    end

    // R8: set mode, gains take effect without enable pulse
    send_word({1'b1, 1'b1, 4'b0110, 5'b00000}, 0);
    chk_outs("R8 mode set word");
    send_word(dac_w(2'b10, 8'hA5), 1);
    chk_outs("R8 immediate DAC update");

    // R7: attempt to clear mode; later DAC write still immediate
    send_word({1'b1, 1'b0, 4'b1001, 5'b01010}, 0);
    chk_outs("R7 clear attempt gains");
    send_word(dac_w(2'b01, 8'h42), 0);
    chk_outs("R7 mode stays single");

    // R8: random single-buffered traffic
    for (int k = 0; k < 100; k++) begin
      w = 11'($urandom);
      send_word(w, int'($urandom % 3));
      chk_outs("R8 random single-buffered");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule